// File: doc/BRIEF.md
# Instruction TLB Pseudo-LRU Replacement Tracker

This block holds the replacement-order state for a four-way instruction translation buffer. The state is six pairwise-ordering bits kept in the top of a 32-bit MMU control register (bits 31:26). Each bit records which of two entries was used more recently. The rest of the register is plain storage that software loads.

Every time the translation buffer uses an entry, the block clears and sets a fixed group of the six bits for that entry. A refill from the unified buffer counts as a use of the refilled entry, and is reported on the same use port. When the buffer needs room, it raises a replacement request. One cycle later the block returns the least recently used entry. If software has loaded an ordering that names no entry, the block flags an error and returns entry 0.

Top module: `itlb_plru_tracker`

## Requirements
- R1: While reset is asserted and after it is released, the control register reads 0, and `victim_vld` and `victim_err` are 0.
- R2: A use of entry 0 clears register bits 31, 30 and 29 on the next clock edge and leaves every other bit unchanged.
- R3: A use of entry 1 sets bit 31 and clears bits 28 and 27 on the next clock edge, leaving the other bits unchanged.
- R4: A use of entry 2 sets bits 30 and 28 and clears bit 26 on the next clock edge, leaving the other bits unchanged.
- R5: A use of entry 3 sets bits 29, 27 and 26 on the next clock edge, leaving the other bits unchanged.
- R6: A replacement request gives `victim_vld` high for exactly the next cycle. `victim_way` is chosen from the register as it stood before that edge, by the first of these rules that holds, tried in the order 0, 1, 2, 3. Entry 0: bits 31, 30 and 29 are all 1. Entry 1: bit 31 is 0 and bits 28 and 27 are 1. Entry 2: bits 30 and 28 are 0 and bit 26 is 1. Entry 3: bits 29, 27 and 26 are all 0. Without a request, `victim_vld` is 0.
- R7: When none of the rules in R6 holds, the response carries `victim_err` = 1 and `victim_way` = 0. `victim_err` is never high without `victim_vld`.
- R8: A software write with no use in the same cycle loads all 32 bits of the register on the next edge.
- R9: A software write and a use in the same cycle take bits 25:0 from the written data. Bits 31:26 take the use update applied to the old ordering bits.
- R10: A use never changes bits 25:0. In a cycle with neither a use nor a write, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_vld | input | 1 | An entry was used or refilled this cycle |
| use_way | input | 2 | Index of the used entry |
| repl_req | input | 1 | Request for a victim entry |
| cfg_wr_en | input | 1 | Software write strobe for the control register |
| cfg_wr_data | input | 32 | Software write data |
| cfg_reg | output | 32 | Current control register contents |
| lru_bits | output | 6 | Ordering bits, register bits 31:26 |
| victim_vld | output | 1 | Victim response valid, one cycle after a request |
| victim_way | output | 2 | Index of the entry to replace |
| victim_err | output | 1 | Ordering bits matched no victim rule |

## Verification
A wrong mask for one entry's use leaves a bit wrong in `cfg_reg` on the very next edge. It also changes which entry a later request returns, so victim checks after sequences of uses show it at a second place. A victim rule that is misordered or mis-masked appears one cycle after the request as a wrong `victim_way`. Loading an inconsistent ordering pattern shows whether the error path falls back to entry 0. A mistake in the write-versus-use priority shows in either the low 26 bits or the ordering field, right after a cycle that carries both.

// File: rtl/plru_pkg.sv
package plru_pkg;

    localparam int NWAYS  = 4;
    localparam int PAIR_W = NWAYS * (NWAYS - 1) / 2;

    // ordering bits forced to 0 when a way is used
    function automatic logic [PAIR_W-1:0] use_clr(input logic [1:0] w);
        case (w)
            2'd0:    use_clr = 6'b111000;
            2'd1:    use_clr = 6'b000110;
            2'd2:    use_clr = 6'b000001;
            default: use_clr = 6'b000000;
        endcase
    endfunction

    // ordering bits forced to 1 when a way is used
    function automatic logic [PAIR_W-1:0] use_set(input logic [1:0] w);
        case (w)
            2'd0:    use_set = 6'b000000;
            2'd1:    use_set = 6'b100000;
            2'd2:    use_set = 6'b010100;
            default: use_set = 6'b001011;
        endcase
    endfunction

    // bits examined by the victim rule of each way
    function automatic logic [PAIR_W-1:0] pick_care(input logic [1:0] w);
        case (w)
            2'd0:    pick_care = 6'b111000;
            2'd1:    pick_care = 6'b100110;
            2'd2:    pick_care = 6'b010101;
            default: pick_care = 6'b001011;
        endcase
    endfunction

    // required values of the examined bits
    function automatic logic [PAIR_W-1:0] pick_want(input logic [1:0] w);
        case (w)
            2'd0:    pick_want = 6'b111000;
            2'd1:    pick_want = 6'b000110;
            2'd2:    pick_want = 6'b000001;
            default: pick_want = 6'b000000;
        endcase
    endfunction

endpackage

// File: rtl/plru_use_update.sv
module plru_use_update
    import plru_pkg::*;
#(
    parameter int WAY_W = 2
) (
    input  logic [PAIR_W-1:0] field_i,
    input  logic              use_vld,
    input  logic [WAY_W-1:0]  use_way,
    output logic [PAIR_W-1:0] field_o
);

    logic [PAIR_W-1:0] clr_m;
    logic [PAIR_W-1:0] set_m;

    always_comb begin
        clr_m = use_clr(use_way);
        set_m = use_set(use_way);
        if (use_vld) begin
            field_o = (field_i & ~clr_m) | set_m;
        end else begin
            field_o = field_i;
        end
    end

endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick
    import plru_pkg::*;
#(
    parameter int WAYS  = NWAYS,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [PAIR_W-1:0] field_i,
    output logic [WAY_W-1:0]  way_o,
    output logic              err_o
);

    logic [WAYS-1:0] match_vec;

    for (genvar g = 0; g < WAYS; g++) begin : g_rule
        assign match_vec[g] =
            ((field_i & pick_care(2'(g))) == pick_want(2'(g)));
    end

    // lowest index wins; no match falls back to way 0 with error
    always_comb begin
        way_o = '0;
        err_o = 1'b1;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                way_o = WAY_W'(i);
                err_o = 1'b0;
            end
        end
    end

endmodule

// File: rtl/itlb_plru_tracker.sv
module itlb_plru_tracker
    import plru_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int FIELD_LSB = 26,
    parameter int WAYS      = NWAYS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_vld,
    input  logic [1:0]       use_way,
    input  logic             repl_req,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wr_data,
    output logic [REG_W-1:0] cfg_reg,
    output logic [5:0]       lru_bits,
    output logic             victim_vld,
    output logic [1:0]       victim_way,
    output logic             victim_err
);

    localparam int WAY_W = $clog2(WAYS);
    localparam int PW    = PAIR_W;

    typedef struct packed {
        logic [REG_W-1:0] ctl;
        logic             vld;
        logic [WAY_W-1:0] way;
        logic             err;
    } trk_t;

    trk_t st_d, st_q;

    logic [PW-1:0]    field_q;
    logic [PW-1:0]    field_upd;
    logic [WAY_W-1:0] pick_way;
    logic             pick_err;

    assign field_q = st_q.ctl[FIELD_LSB +: PW];

    plru_use_update #(.WAY_W(WAY_W)) u_update (
        .field_i (field_q),
        .use_vld (use_vld),
        .use_way (use_way),
        .field_o (field_upd)
    );

    plru_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .field_i (field_q),
        .way_o   (pick_way),
        .err_o   (pick_err)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_wr_en) begin
            st_d.ctl = cfg_wr_data;
        end
        if (use_vld) begin
            st_d.ctl[FIELD_LSB +: PW] = field_upd;
        end
        st_d.vld = repl_req;
        st_d.way = repl_req ? pick_way : '0;
        st_d.err = repl_req & pick_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_reg    = st_q.ctl;
    assign lru_bits   = st_q.ctl[FIELD_LSB +: PW];
    assign victim_vld = st_q.vld;
    assign victim_way = st_q.way;
    assign victim_err = st_q.err;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (cfg_reg == '0 && !victim_vld && !victim_err)); // R1
    AST_USE0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (use_vld && use_way == 2'd0) |=> (lru_bits[5:3] == 3'b000)); // R2
    AST_USE1_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (use_vld && use_way == 2'd1) |=> (lru_bits[5] && lru_bits[2:1] == 2'b00)); // R3
    AST_USE2_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (use_vld && use_way == 2'd2) |=> (lru_bits[4] && lru_bits[2] && !lru_bits[0])); // R4
    AST_USE3_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (use_vld && use_way == 2'd3) |=> (lru_bits[3] && lru_bits[1] && lru_bits[0])); // R5
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        repl_req |=> victim_vld); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !repl_req |=> !victim_vld); // R6
    AST_ERR_WAY0: assert property (@(posedge clk) disable iff (!rst_n)
        victim_err |-> (victim_vld && victim_way == '0)); // R7
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !use_vld) |=> (cfg_reg == $past(cfg_wr_data))); // R8
    AST_LOW_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && use_vld) |=> (cfg_reg[25:0] == $past(cfg_wr_data[25:0]))); // R9
    AST_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(cfg_reg[25:0])); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_en && !use_vld) |=> $stable(cfg_reg)); // R10

endmodule

// File: tb/test_itlb_plru_tracker.sv
module test_itlb_plru_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        use_vld = 1'b0;
    logic [1:0]  use_way = 2'd0;
    logic        repl_req = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = 32'd0;
    logic [31:0] cfg_reg;
    logic [5:0]  lru_bits;
    logic        victim_vld;
    logic [1:0]  victim_way;
    logic        victim_err;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model = 32'd0;

    typedef struct {
        logic [31:0] ctl;
        logic        vld;
        logic [1:0]  way;
        logic        err;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    itlb_plru_tracker i_itlb_plru_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .use_vld     (use_vld),
        .use_way     (use_way),
        .repl_req    (repl_req),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_reg     (cfg_reg),
        .lru_bits    (lru_bits),
        .victim_vld  (victim_vld),
        .victim_way  (victim_way),
        .victim_err  (victim_err)
    );

    // field bit k below is register bit 26+k
    function automatic logic [5:0] m_use(input logic [5:0] f, input logic [1:0] w);
        case (w)
            2'd0:    m_use = {3'b000, f[2:0]};                    // R2
            2'd1:    m_use = {1'b1, f[4:3], 2'b00, f[0]};         // R3
            2'd2:    m_use = {f[5], 1'b1, f[3], 1'b1, f[1], 1'b0}; // R4
            default: m_use = f | 6'b001011;                       // R5
        endcase
    endfunction

    function automatic logic [2:0] m_pick(input logic [5:0] f);
        // {err, way}, R6 and R7
        if (f[5] && f[4] && f[3])        m_pick = 3'b000;
        else if (!f[5] && f[2] && f[1])  m_pick = 3'b001;
        else if (!f[4] && !f[2] && f[0]) m_pick = 3'b010;
        else if (!f[3] && !f[1] && !f[0]) m_pick = 3'b011;
        else                             m_pick = 3'b100;
    endfunction

    task automatic step(input logic h, input logic [1:0] w, input logic rq,
                        input logic wr, input logic [31:0] d, input string tag);
        exp_t e;
        logic [2:0] pk;
        logic [31:0] nx;
        @(negedge clk);
        use_vld = h; use_way = w; repl_req = rq; cfg_wr_en = wr; cfg_wr_data = d;
        pk = m_pick(model[31:26]);
        e.vld = rq;
        e.way = rq ? pk[1:0] : 2'd0;
        e.err = rq & pk[2];
        nx = wr ? d : model;
        if (h) nx[31:26] = m_use(model[31:26], w);
        model = nx;
        e.ctl = nx;
        e.tag = tag;
        @(posedge clk);
        #1;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (cfg_reg !== e.ctl || victim_vld !== e.vld ||
                victim_way !== e.way || victim_err !== e.err) begin
                fails++;
                $display("FAIL %s: got reg=%h vld=%b way=%0d err=%b, expected reg=%h vld=%b way=%0d err=%b",
                         e.tag, cfg_reg, victim_vld, victim_way, victim_err,
                         e.ctl, e.vld, e.way, e.err);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (cfg_reg !== 32'd0 || victim_vld !== 1'b0 || victim_err !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset: got reg=%h vld=%b err=%b, expected 0 0 0",
                     cfg_reg, victim_vld, victim_err);
        end
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R1 after reset");
        step(0, 0, 1, 0, 0, "R6 victim from reset state");
        // walk the uses 0,1,2,3
        step(1, 0, 0, 0, 0, "R2 use way 0");
        step(1, 1, 0, 0, 0, "R3 use way 1");
        step(1, 2, 0, 0, 0, "R4 use way 2");
        step(1, 3, 0, 0, 0, "R5 use way 3");
        step(0, 0, 1, 0, 0, "R6 oldest is way 0");
        step(1, 0, 0, 0, 0, "R2 reuse way 0");
        step(0, 0, 1, 0, 0, "R6 oldest is way 1");
        step(1, 1, 1, 0, 0, "R6 request sees state before use");
        step(0, 0, 1, 0, 0, "R6 after way 1 use");
        step(1, 2, 0, 0, 0, "R4 use way 2 again");
        step(0, 0, 1, 0, 0, "R6 victim after way 2");
        // software writes
        step(0, 0, 0, 1, 32'h5A5A_1234, "R8 full write");
        step(0, 0, 1, 0, 0, "R6 victim from written pattern");
        step(0, 0, 0, 0, 0, "R10 idle hold");
        step(1, 3, 0, 0, 0, "R10 use keeps low bits");
        step(1, 1, 0, 1, 32'h0F0F_ABCD, "R9 write with use");
        step(1, 0, 0, 1, 32'hFFFF_FFFF, "R9 write with way 0 use");
        // inconsistent ordering: field 110001
        step(0, 0, 0, 1, 32'hC400_0077, "R8 load inconsistent field");
        step(0, 0, 1, 0, 0, "R7 no rule matches");
        step(0, 0, 0, 1, 32'hFC00_0000, "R8 load all ones");
        step(0, 0, 1, 0, 0, "R6 all ones gives way 0");
        step(0, 0, 0, 1, 32'h1800_0000, "R8 load way 1 pattern");
        step(0, 0, 1, 0, 0, "R6 way 1 rule");
        step(0, 0, 0, 1, 32'h0400_0000, "R8 load way 2 pattern");
        step(0, 0, 1, 0, 0, "R6 way 2 rule");
        step(0, 0, 0, 0, 0, "R6 no request no valid");
        step(0, 0, 0, 0, 0, "R10 final hold");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule